// File: doc/BRIEF.md
# Row-Level Flash Write-Protection Controller

This block keeps the write-protection state for the rows of one or more flash macros, along with one chip-wide protection byte. Each row has a single protection bit. The bits are packed eight to a byte, so a macro with `ROWS_PER_MACRO` rows needs `ROWS_PER_MACRO/8` protection bytes. Software streams those bytes, one per transfer, into a staging latch that belongs to the chosen macro. Filling always starts at latch byte zero. A commit command then copies the staged bytes into that macro's supervisory row.

A commit on macro zero also stores the chip-wide byte. That byte is passed as an argument of the command and never goes through the latch. It models the last byte of macro zero's supervisory row. A combinational query port reports whether a given row of a given macro is write-protected. The timing of the nonvolatile cells and the charge pump are not modelled.

The load port uses a valid/ready handshake. A byte transfers on a clock edge where `ld_valid` and `ld_ready` are both high. `ld_ready` drops for exactly one cycle after a command is accepted. The load source must hold its byte stable until the transfer happens.

The command port works the same way. `cmd_valid` is held until `cmd_ready` is seen high, and the block then accepts at most one command every two cycles. Query and status pins are plain signals.

Top module: `wp_prot_ctrl`

## Requirements
- R1: After reset, every row of every macro reads as unprotected (`q_deny` = 0), `chip_prot` is 0, `cmd_done` is 0, and both `ld_ready` and `cmd_ready` are 1.
- R2: After a command is accepted, `ld_ready` and `cmd_ready` are both 0 for the next cycle only, and both are 1 again in the cycle after that.
- R3: Accepted load bytes fill the latch of `ld_macro` in order. The first byte after reset or after a commit goes to latch byte 0, the next to byte 1, and so on.
- R4: After a successful commit, row r of that macro is reported protected (`q_deny` = 1) exactly when bit (r mod 8) of committed byte (r div 8) is 1, where bit 0 is the least significant bit.
- R5: A command accepted at clock edge E produces a one-cycle `cmd_done` pulse in the cycle that follows edge E+1. New protection and chip-byte values become visible in that same cycle, and not before it.
- R6: If the number of bytes loaded for the target macro since its last commit differs from `ROWS_PER_MACRO/8`, whether fewer or more, the commit raises `cmd_err` together with `cmd_done` and changes no stored setting.
- R7: A successful commit on macro 0 stores `cmd_chip` into `chip_prot`. A commit on any other macro leaves `chip_prot` unchanged.
- R8: A load accepted in the same cycle as a command counts toward that command's load total and latch contents.
- R9: Every commit, whether it succeeds or fails, restarts the load count and latch position of the target macro at zero.
- R10: A commit changes only the protection bits of its own macro.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load byte valid |
| ld_ready | output | 1 | Load byte accepted when high |
| ld_macro | input | MW | Macro whose latch receives the byte |
| ld_data | input | 8 | Protection byte |
| cmd_valid | input | 1 | Commit request valid |
| cmd_ready | output | 1 | Commit request accepted when high |
| cmd_macro | input | MW | Macro to commit |
| cmd_chip | input | 8 | Chip-wide protection byte (used for macro 0) |
| cmd_done | output | 1 | One-cycle commit completion pulse |
| cmd_err | output | 1 | Commit rejected due to load count mismatch (valid with cmd_done) |
| chip_prot | output | 8 | Stored chip-wide protection byte |
| q_macro | input | MW | Query macro |
| q_row | input | RW | Query row |
| q_deny | output | 1 | High when the queried row is write-protected |

## Verification
A load byte and a commit command can both be accepted on the same clock edge. The block must then count that byte toward the commit it is accepting. To provoke this, the bench stages one byte fewer than required and raises both `ld_valid` and `cmd_valid` in the same cycle, carrying the missing byte. The scoreboard expects that commit to succeed, and the query sweep expects the last protection byte to match the byte carried alongside the command. A dropped or late-counted byte therefore shows up either as an unexpected `cmd_err` or as wrong deny bits in the final eight rows.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef logic [7:0] prot_byte_t;

  function automatic int unsigned bytes_for_rows(input int unsigned rows);
    return rows / 8;
  endfunction
endpackage

// File: rtl/wp_page_latch.sv
module wp_page_latch
  import wp_pkg::*;
#(
  parameter int unsigned NBYTES = 8,
  parameter int unsigned CW     = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  prot_byte_t                     wr_data,
  input  logic                           clr,
  output logic [NBYTES-1:0][7:0]         bytes_o,
  output logic [CW-1:0]                  count_o
);
  localparam logic [CW-1:0] FULL = CW'(NBYTES);
  localparam logic [CW-1:0] OVER = CW'(NBYTES + 1);

  logic [NBYTES-1:0][7:0] mem_q;
  logic [CW-1:0]          cnt_q;

  // count saturates one past full so overfill is still detectable
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (wr_en && cnt_q != OVER) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (wr_en && !clr && cnt_q < FULL) begin
      mem_q[cnt_q] <= wr_data;
    end
  end

  assign bytes_o = mem_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/wp_super_row.sv
module wp_super_row #(
  parameter int unsigned NBITS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NBITS-1:0] bits_in,
  output logic [NBITS-1:0] bits_o
);
  logic [NBITS-1:0] row_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     row_q <= '0;
    else if (wr_en) row_q <= bits_in;
  end

  assign bits_o = row_q;
endmodule

// File: rtl/wp_cmd_ctrl.sv
module wp_cmd_ctrl
  import wp_pkg::*;
#(
  parameter int unsigned NUM_MACROS = 2,
  parameter int unsigned MW         = 1,
  parameter int unsigned CW         = 4,
  parameter int unsigned NBYTES     = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_valid,
  input  logic [MW-1:0]                  cmd_macro,
  input  prot_byte_t                     cmd_chip,
  input  logic [NUM_MACROS-1:0][CW-1:0]  counts,
  output logic                           busy_o,
  output logic [MW-1:0]                  mac_o,
  output logic                           commit_we_o,
  output prot_byte_t                     chip_o,
  output logic                           done_o,
  output logic                           err_o
);
  localparam logic [CW-1:0] FULL = CW'(NBYTES);

  logic       busy_q, done_q, err_q;
  logic [MW-1:0] mac_q;
  prot_byte_t chip_q;
  logic       match;

  assign match = (counts[mac_q] == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mac_q  <= '0;
      chip_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= busy_q;
      err_q  <= busy_q && !match;
      if (busy_q) begin
        busy_q <= 1'b0;
      end else if (cmd_valid) begin
        busy_q <= 1'b1;
        mac_q  <= cmd_macro;
        chip_q <= cmd_chip;
      end
    end
  end

  assign busy_o      = busy_q;
  assign mac_o       = mac_q;
  assign commit_we_o = busy_q && match;
  assign chip_o      = chip_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
endmodule

// File: rtl/wp_prot_ctrl.sv
module wp_prot_ctrl
  import wp_pkg::*;
#(
  parameter int unsigned NUM_MACROS     = 2,
  parameter int unsigned ROWS_PER_MACRO = 64,
  parameter int unsigned MW             = (NUM_MACROS > 1) ? $clog2(NUM_MACROS) : 1,
  parameter int unsigned RW             = $clog2(ROWS_PER_MACRO)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [MW-1:0] ld_macro,
  input  logic [7:0]    ld_data,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [MW-1:0] cmd_macro,
  input  logic [7:0]    cmd_chip,
  output logic          cmd_done,
  output logic          cmd_err,
  output logic [7:0]    chip_prot,
  input  logic [MW-1:0] q_macro,
  input  logic [RW-1:0] q_row,
  output logic          q_deny
);
  localparam int unsigned NBYTES = bytes_for_rows(ROWS_PER_MACRO);
  localparam int unsigned CW     = $clog2(NBYTES + 2);

  logic                          busy, commit_we;
  logic [MW-1:0]                 cur_mac;
  prot_byte_t                    cur_chip;
  logic                          ld_fire;
  logic [NUM_MACROS-1:0][CW-1:0] counts;
  logic [NUM_MACROS-1:0][ROWS_PER_MACRO-1:0] prot_bits;
  prot_byte_t                    chip_q;

  assign ld_ready  = !busy;
  assign cmd_ready = !busy;
  assign ld_fire   = ld_valid && ld_ready;

  wp_cmd_ctrl #(
    .NUM_MACROS(NUM_MACROS), .MW(MW), .CW(CW), .NBYTES(NBYTES)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_macro  (cmd_macro),
    .cmd_chip   (cmd_chip),
    .counts     (counts),
    .busy_o     (busy),
    .mac_o      (cur_mac),
    .commit_we_o(commit_we),
    .chip_o     (cur_chip),
    .done_o     (cmd_done),
    .err_o      (cmd_err)
  );

  for (genvar m = 0; m < NUM_MACROS; m++) begin : g_macro
    logic [NBYTES-1:0][7:0] latch_bytes;
    logic                   sel_ld, sel_cm;

    assign sel_ld = ld_fire && (ld_macro == MW'(m));
    assign sel_cm = busy && (cur_mac == MW'(m));

    wp_page_latch #(.NBYTES(NBYTES), .CW(CW)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (sel_ld),
      .wr_data(ld_data),
      .clr    (sel_cm),
      .bytes_o(latch_bytes),
      .count_o(counts[m])
    );

    // packed byte order: bit r of the row vector is bit r%8 of byte r/8
    wp_super_row #(.NBITS(ROWS_PER_MACRO)) u_row (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (sel_cm && commit_we),
      .bits_in(latch_bytes),
      .bits_o (prot_bits[m])
    );
  end

  // chip-wide byte: held only by macro zero's supervisory row
  always_ff @(posedge clk) begin
    if (!rst_n)                          chip_q <= '0;
    else if (commit_we && cur_mac == '0) chip_q <= cur_chip;
  end

  assign chip_prot = chip_q;
  assign q_deny    = prot_bits[q_macro][q_row];
endmodule

// File: rtl/wp_prot_ctrl_chk.sv
module wp_prot_ctrl_chk #(
  parameter int unsigned MW = 1,
  parameter int unsigned RW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_ready,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [MW-1:0] cmd_macro,
  input logic          cmd_done,
  input logic          cmd_err,
  input logic [7:0]    chip_prot,
  input logic [MW-1:0] q_macro,
  input logic [RW-1:0] q_row,
  input logic          q_deny
);
  p_busy_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!cmd_ready && !ld_ready));

  p_done_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> ##1 cmd_done);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);

  p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> cmd_done);

  p_err_keeps_chip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && cmd_err) |-> $stable(chip_prot));

  p_chip_other_macro_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && $past(cmd_macro, 2) != '0) |-> $stable(chip_prot));

  p_query_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_done && $stable(q_macro) && $stable(q_row)) |-> $stable(q_deny));
endmodule

bind wp_prot_ctrl wp_prot_ctrl_chk #(.MW(MW), .RW(RW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ld_ready (ld_ready),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_macro(cmd_macro),
  .cmd_done (cmd_done),
  .cmd_err  (cmd_err),
  .chip_prot(chip_prot),
  .q_macro  (q_macro),
  .q_row    (q_row),
  .q_deny   (q_deny)
);

// File: tb/test_wp_prot_ctrl.sv
`timescale 1ns/1ps
module test_wp_prot_ctrl;
  localparam int NM = 2;
  localparam int ROWS = 64;
  localparam int PB = ROWS / 8;
  localparam int MW = 1;
  localparam int RW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 0, ld_ready;
  logic [MW-1:0] ld_macro = '0;
  logic [7:0] ld_data = '0;
  logic cmd_valid = 0, cmd_ready;
  logic [MW-1:0] cmd_macro = '0;
  logic [7:0] cmd_chip = '0;
  logic cmd_done, cmd_err;
  logic [7:0] chip_prot;
  logic [MW-1:0] q_macro = '0;
  logic [RW-1:0] q_row = '0;
  logic q_deny;

  always #2.5 clk = ~clk;

  wp_prot_ctrl #(.NUM_MACROS(NM), .ROWS_PER_MACRO(ROWS)) i_wp_prot_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_macro(ld_macro), .ld_data(ld_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_macro(cmd_macro), .cmd_chip(cmd_chip),
    .cmd_done(cmd_done), .cmd_err(cmd_err), .chip_prot(chip_prot),
    .q_macro(q_macro), .q_row(q_row), .q_deny(q_deny)
  );

  int n_tests = 0;
  int n_fail = 0;
  bit exp_q[$];
  logic [ROWS-1:0] mdl_prot [NM];
  logic [7:0] mdl_latch [NM][PB];
  int ld_cnt [NM];
  logic [7:0] mdl_chip = 8'h00;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 29) ^ 8'hA5);
  endfunction

  function automatic void mdl_load(input int m, input logic [7:0] d);
    if (ld_cnt[m] < PB) mdl_latch[m][ld_cnt[m]] = d;
    if (ld_cnt[m] <= PB) ld_cnt[m]++;
  endfunction

  task automatic load(input int m, input logic [7:0] d);
    @(negedge clk);
    while (!ld_ready) @(negedge clk);
    ld_valid = 1'b1; ld_macro = MW'(m); ld_data = d;
    mdl_load(m, d);
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic load_n(input int m, input int seed, input int n);
    for (int i = 0; i < n; i++) load(m, pat(seed, i));
  endtask

  // driver: issues a commit and pushes the expected outcome into the scoreboard
  task automatic commit(input int m, input logic [7:0] chip,
                        input bit with_ld, input logic [7:0] d);
    bit err;
    logic [7:0] old_chip;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_macro = MW'(m); cmd_chip = chip;
    if (with_ld) begin
      ld_valid = 1'b1; ld_macro = MW'(m); ld_data = d;
      mdl_load(m, d);
    end
    old_chip = mdl_chip;
    err = (ld_cnt[m] != PB);
    exp_q.push_back(err);
    if (!err) begin
      for (int b = 0; b < PB; b++)
        for (int k = 0; k < 8; k++) mdl_prot[m][b*8+k] = mdl_latch[m][b][k];
      if (m == 0) mdl_chip = chip;
    end
    ld_cnt[m] = 0;
    @(negedge clk);
    cmd_valid = 1'b0; ld_valid = 1'b0;
    check(!ld_ready && !cmd_ready, "R2", "ready low after accept",
          {ld_ready, cmd_ready}, 0);
    check(chip_prot == old_chip, "R5", "chip byte not yet updated", chip_prot, old_chip);
    @(negedge clk);
    check(ld_ready && cmd_ready, "R2", "ready back high", {ld_ready, cmd_ready}, 3);
    check(chip_prot == mdl_chip, "R7", "chip byte after commit", chip_prot, mdl_chip);
  endtask

  // monitor: pops the scoreboard on every completion pulse
  always @(negedge clk) begin
    if (rst_n && cmd_done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "unexpected cmd_done", 1, 0);
      end else begin
        bit e;
        e = exp_q.pop_front();
        check(cmd_err == e, e ? "R6" : "R5", "commit status", cmd_err, e);
      end
    end
  end

  task automatic sweep(input string req);
    for (int m = 0; m < NM; m++)
      for (int r = 0; r < ROWS; r++) begin
        q_macro = MW'(m); q_row = RW'(r);
        #0.5;
        check(q_deny == mdl_prot[m][r], req, $sformatf("deny m%0d row%0d", m, r),
              q_deny, mdl_prot[m][r]);
      end
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "R5", "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int m = 0; m < NM; m++) begin
      mdl_prot[m] = '0; ld_cnt[m] = 0;
      for (int b = 0; b < PB; b++) mdl_latch[m][b] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(chip_prot == 8'h00, "R1", "chip after reset", chip_prot, 0);
    check(!cmd_done, "R1", "done after reset", cmd_done, 0);
    check(ld_ready && cmd_ready, "R1", "ready after reset", {ld_ready, cmd_ready}, 3);
    sweep("R1");

    // R3 R4 R7: full load and commit on macro 0
    load_n(0, 1, PB);
    commit(0, 8'h5A, 1'b0, 8'h00);
    sweep("R4");

    // R7 R10: commit on macro 1 keeps chip byte and macro 0 bits
    load_n(1, 2, PB);
    commit(1, 8'hC3, 1'b0, 8'h00);
    sweep("R10");

    // R6: too few, too many, none
    load_n(1, 3, PB - 3);
    commit(1, 8'h11, 1'b0, 8'h00);
    load_n(0, 4, PB + 1);
    commit(0, 8'h22, 1'b0, 8'h00);
    commit(0, 8'h33, 1'b0, 8'h00);
    sweep("R6");

    // R9: after failed commits the latch refills from byte 0
    load_n(0, 5, PB);
    commit(0, 8'h96, 1'b0, 8'h00);
    sweep("R9");

    // R8: last byte accepted together with the command
    load_n(1, 6, PB - 1);
    commit(1, 8'h44, 1'b1, 8'hF0);
    sweep("R8");

    // R3: all-ones and single-bit bytes map to the right rows
    for (int i = 0; i < PB; i++) load(0, (i == 0) ? 8'h01 : (i == PB - 1) ? 8'h80 : 8'hFF);
    commit(0, 8'h00, 1'b0, 8'h00);
    sweep("R3");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R5", "all commits completed", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule